// File: doc/BRIEF.md
# Time-of-flight speed classifier

The block sorts beam particles into a fast and a slow class from the time between an upstream counter hit and a downstream counter hit. Each upstream hit goes through two shift-register delays. Each delayed copy is then stretched into a window: a short early window for the fast class and a long later window for the slow class. The downstream hit opens its own short window. The class whose window overlaps the downstream window first is reported, and the fast class wins when both overlap. All timing is in clock cycles. The delays and widths are parameters given in nanoseconds and divided by the clock period, which is 2.5 ns (400 MHz) by default.

A classified event produces an accept pulse only while two readiness inputs are both high. One is the wire-chamber controller's "ready for a trigger" level and the other is the digitizer's "done with earlier triggers" level. Accepted events are counted per class in counters that software can clear synchronously.

Top module: `tof_classifier`

## Requirements
- R1: Reset state: prompt_o, slow_o, accept_o, prompt_cnt_o and slow_cnt_o are all zero while rst_ni is low and after its release until an event is classified.
- R2: A cycle with ds_hit_i high opens a downstream window of 4 cycles (default parameters). Take a us_hit_i pulse sampled at edge 0 and a ds_hit_i pulse sampled at edge t. For t from 23 to 29, prompt_o pulses high for one cycle after edge max(t,26)+1.
- R3: With the same stimulus, for t from 30 to 65 slow_o pulses high for one cycle after edge max(t,30)+1. The slow window starts 30 cycles after the upstream hit and lasts 36 cycles.
- R4: For t of 22 or less, t of 66 or more, or an upstream hit with no downstream hit, neither prompt_o nor slow_o is raised.
- R5: Priority: when both windows would overlap the downstream window (t from 27 to 29), only prompt_o fires, and slow_o stays low for the rest of that event.
- R6: prompt_o and slow_o are never high together. Each pulse lasts exactly one cycle, and at most one class pulse is given per event. An event ends when all three windows are closed.
- R7: accept_o is high in exactly the cycles in which prompt_o or slow_o is high and ctrl_rdy_i and dig_rdy_i were both high at the edge that raised that class output.
- R8: prompt_cnt_o and slow_cnt_o (16 bits) each increase by one, at the edge that raises accept_o, for each accepted prompt or slow event. They stay unchanged for events that are not accepted.
- R9: cnt_clr_i high at an edge sets both counters to zero at that edge, and it takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_hit_i | input | 1 | Upstream counter hit |
| ds_hit_i | input | 1 | Downstream counter hit |
| ctrl_rdy_i | input | 1 | Chamber controller ready for a trigger |
| dig_rdy_i | input | 1 | Digitizer finished earlier triggers |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| prompt_o | output | 1 | Fast-class pulse |
| slow_o | output | 1 | Slow-class pulse |
| accept_o | output | 1 | Class pulse passed by both ready inputs |
| prompt_cnt_o | output | 16 | Accepted fast-class events |
| slow_cnt_o | output | 16 | Accepted slow-class events |

## Verification
The assertions check on every cycle that the two class outputs exclude each other and last one cycle, and that accept follows a class pulse together with both ready inputs. They also check that the counters either step by one on an accepted event, clear, or hold. Only the bench scenarios can show where the class boundaries fall in cycles (t of 22/23, 29/30 and 65/66) and that fast-over-slow priority holds across the overlap range. The bench also shows that a whole event gives one pulse and not a later second one.

// File: rtl/tof_pkg.sv
package tof_pkg;
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_PROMPT = 2'd1,
    CLS_SLOW   = 2'd2
  } tof_class_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000) / clk_ps;
  endfunction
endpackage

// File: rtl/tof_delay_line.sv
module tof_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH:0] tap;
  assign tap[0] = d_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap[i+1] <= 1'b0;
      else         tap[i+1] <= tap[i];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/tof_stretch.sv
module tof_stretch #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic win_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH);

  logic [CW-1:0] cnt;

  // retriggerable: a new hit reloads the full width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (trig_i)      cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign win_o = (cnt != '0);
endmodule

// File: rtl/tof_event_cnt.sv
module tof_event_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tof_classifier.sv
module tof_classifier
  import tof_pkg::*;
#(
  parameter int unsigned CLK_PS    = 2500,
  parameter int unsigned DS_W_NS   = 10,
  parameter int unsigned PR_DLY_NS = 65,
  parameter int unsigned PR_W_NS   = 10,
  parameter int unsigned SL_DLY_NS = 75,
  parameter int unsigned SL_W_NS   = 90,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_hit_i,
  input  logic             ds_hit_i,
  input  logic             ctrl_rdy_i,
  input  logic             dig_rdy_i,
  input  logic             cnt_clr_i,
  output logic             prompt_o,
  output logic             slow_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] prompt_cnt_o,
  output logic [CNT_W-1:0] slow_cnt_o
);
  localparam int unsigned DS_W   = ns_to_cyc(DS_W_NS, CLK_PS);
  localparam int unsigned PR_DLY = ns_to_cyc(PR_DLY_NS, CLK_PS);
  localparam int unsigned PR_W   = ns_to_cyc(PR_W_NS, CLK_PS);
  localparam int unsigned SL_DLY = ns_to_cyc(SL_DLY_NS, CLK_PS);
  localparam int unsigned SL_W   = ns_to_cyc(SL_W_NS, CLK_PS);

  logic us_pr_dly, us_sl_dly;
  logic ds_win, pr_win, sl_win;

  tof_delay_line #(.DEPTH(PR_DLY)) i_pr_dly (
    .clk_i, .rst_ni, .d_i(us_hit_i), .q_o(us_pr_dly)
  );
  tof_delay_line #(.DEPTH(SL_DLY)) i_sl_dly (
    .clk_i, .rst_ni, .d_i(us_hit_i), .q_o(us_sl_dly)
  );

  tof_stretch #(.WIDTH(DS_W)) i_ds_win (
    .clk_i, .rst_ni, .trig_i(ds_hit_i), .win_o(ds_win)
  );
  tof_stretch #(.WIDTH(PR_W)) i_pr_win (
    .clk_i, .rst_ni, .trig_i(us_pr_dly), .win_o(pr_win)
  );
  tof_stretch #(.WIDTH(SL_W)) i_sl_win (
    .clk_i, .rst_ni, .trig_i(us_sl_dly), .win_o(sl_win)
  );

  logic       evt_done;
  logic       evt_active;
  logic       rdy_ok;
  tof_class_e fire;

  assign evt_active = ds_win | pr_win | sl_win;
  assign rdy_ok     = ctrl_rdy_i & dig_rdy_i;

  // prompt wins; one class per event, held off until all windows close
  always_comb begin
    fire = CLS_NONE;
    if (!evt_done) begin
      if (pr_win && ds_win)      fire = CLS_PROMPT;
      else if (sl_win && ds_win) fire = CLS_SLOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_done <= 1'b0;
      prompt_o <= 1'b0;
      slow_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      prompt_o <= (fire == CLS_PROMPT);
      slow_o   <= (fire == CLS_SLOW);
      accept_o <= (fire != CLS_NONE) && rdy_ok;
      if (fire != CLS_NONE) evt_done <= 1'b1;
      else if (!evt_active) evt_done <= 1'b0;
    end
  end

  tof_event_cnt #(.W(CNT_W)) i_pr_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i),
    .inc_i((fire == CLS_PROMPT) && rdy_ok), .cnt_o(prompt_cnt_o)
  );
  tof_event_cnt #(.W(CNT_W)) i_sl_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i),
    .inc_i((fire == CLS_SLOW) && rdy_ok), .cnt_o(slow_cnt_o)
  );
endmodule

// File: rtl/tof_classifier_chk.sv
module tof_classifier_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             us_hit_i,
  input logic             ds_hit_i,
  input logic             ctrl_rdy_i,
  input logic             dig_rdy_i,
  input logic             cnt_clr_i,
  input logic             prompt_o,
  input logic             slow_o,
  input logic             accept_o,
  input logic [CNT_W-1:0] prompt_cnt_o,
  input logic [CNT_W-1:0] slow_cnt_o
);
  p_one_class_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prompt_o && slow_o));

  p_prompt_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prompt_o |=> !prompt_o);

  p_slow_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |=> !slow_o);

  p_accept_cls_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (prompt_o || slow_o));

  p_accept_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(ctrl_rdy_i && dig_rdy_i));

  p_prompt_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_clr_i)) |->
      (prompt_cnt_o == ((accept_o && prompt_o) ? $past(prompt_cnt_o) + 1'b1
                                               : $past(prompt_cnt_o))));

  p_slow_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_clr_i)) |->
      (slow_cnt_o == ((accept_o && slow_o) ? $past(slow_cnt_o) + 1'b1
                                           : $past(slow_cnt_o))));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_clr_i) |-> (prompt_cnt_o == '0 && slow_cnt_o == '0));
endmodule

bind tof_classifier tof_classifier_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tof_classifier.sv
module test_tof_classifier;
  localparam int PR_DLY = 26;
  localparam int SL_DLY = 30;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        us_hit_i = 1'b0, ds_hit_i = 1'b0;
  logic        ctrl_rdy_i = 1'b1, dig_rdy_i = 1'b1, cnt_clr_i = 1'b0;
  logic        prompt_o, slow_o, accept_o;
  logic [15:0] prompt_cnt_o, slow_cnt_o;

  int n_chk = 0, n_fail = 0;
  int exp_pc = 0, exp_sc = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tof_classifier i_tof_classifier (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cls: 0 none, 1 prompt, 2 slow; t<0 means no downstream hit
  task automatic evt_case(input int t, input int cls, input bit ctrl, input bit dig,
                          input string req);
    int p_at = -1, s_at = -1, p_n = 0, s_n = 0, a_n = 0, a_bad = 0;
    int exp_at;
    ctrl_rdy_i = ctrl;
    dig_rdy_i  = dig;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_i);
      if (k > 0) begin
        if (prompt_o) begin p_n++; if (p_at < 0) p_at = k; end
        if (slow_o)   begin s_n++; if (s_at < 0) s_at = k; end
        if (accept_o) a_n++;
        if (accept_o != ((prompt_o || slow_o) && ctrl && dig)) a_bad++;
      end
      us_hit_i = (k == 0);
      ds_hit_i = (t >= 0) && (k == t);
    end
    us_hit_i = 1'b0;
    ds_hit_i = 1'b0;
    chk(p_n == (cls == 1 ? 1 : 0), {req, " prompt count"}, p_n, cls == 1 ? 1 : 0);
    chk(s_n == (cls == 2 ? 1 : 0), {req, " slow count"}, s_n, cls == 2 ? 1 : 0);
    if (cls == 1) begin
      exp_at = imax(t, PR_DLY) + 2;
      chk(p_at == exp_at, {req, " prompt cycle"}, p_at, exp_at);
    end
    if (cls == 2) begin
      exp_at = imax(t, SL_DLY) + 2;
      chk(s_at == exp_at, {req, " slow cycle"}, s_at, exp_at);
    end
    chk(a_bad == 0, "R7 accept vs class and ready", a_bad, 0);
    chk(a_n == ((cls != 0 && ctrl && dig) ? 1 : 0), "R7 accept count", a_n,
        (cls != 0 && ctrl && dig) ? 1 : 0);
    if (ctrl && dig && cls == 1) exp_pc++;
    if (ctrl && dig && cls == 2) exp_sc++;
    chk(prompt_cnt_o == 16'(exp_pc), "R8 prompt counter", prompt_cnt_o, exp_pc);
    chk(slow_cnt_o == 16'(exp_sc), "R8 slow counter", slow_cnt_o, exp_sc);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(!prompt_o && !slow_o && !accept_o, "R1 reset outputs",
        {prompt_o, slow_o, accept_o}, 0);
    chk(prompt_cnt_o == 0 && slow_cnt_o == 0, "R1 reset counters",
        prompt_cnt_o + slow_cnt_o, 0);
  endtask

  task automatic t_prompt;
    evt_case(23, 1, 1, 1, "R2 t=23 lower edge");
    evt_case(26, 1, 1, 1, "R2 t=26");
    evt_case(25, 1, 1, 1, "R2 t=25");
  endtask

  task automatic t_slow;
    evt_case(30, 2, 1, 1, "R3 t=30 lower edge");
    evt_case(45, 2, 1, 1, "R3 t=45");
    evt_case(65, 2, 1, 1, "R3 t=65 upper edge");
  endtask

  task automatic t_none;
    evt_case(22, 0, 1, 1, "R4 t=22 early");
    evt_case(66, 0, 1, 1, "R4 t=66 late");
    evt_case(-1, 0, 1, 1, "R4 no downstream");
  endtask

  task automatic t_priority;
    evt_case(27, 1, 1, 1, "R5 t=27 overlap");
    evt_case(29, 1, 1, 1, "R5 t=29 overlap");
  endtask

  task automatic t_inhibit;
    evt_case(24, 1, 0, 1, "R7 ctrl not ready");
    evt_case(40, 2, 1, 0, "R7 digitizer busy");
    evt_case(50, 2, 0, 0, "R8 both busy");
  endtask

  task automatic t_clear;
    @(negedge clk_i);
    cnt_clr_i = 1'b1;
    @(negedge clk_i);
    cnt_clr_i = 1'b0;
    exp_pc = 0;
    exp_sc = 0;
    chk(prompt_cnt_o == 0, "R9 prompt counter cleared", prompt_cnt_o, 0);
    chk(slow_cnt_o == 0, "R9 slow counter cleared", slow_cnt_o, 0);
    evt_case(28, 1, 1, 1, "R9 count after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_prompt();
    t_slow();
    t_none();
    t_priority();
    t_inhibit();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule